// File: doc/BRIEF.md
# Power-Mode Regulator Control Register

This block holds one 32-bit control and status word for the on-chip voltage regulators and turns it into the enable and level codes that the regulators need in the power mode the chip is in. Software reaches the word through a plain register bus with an address, a write enable, write data and combinational read data. The block also receives the live power mode, one power-loss pulse for each retained domain, and a fuse input that allows software to choose the active-mode core voltage.

Two status flags record whether the backup domain and the SRAM still hold valid contents. Software writes these flags, and the matching loss pulse clears them. The remaining fields pick the user LDO level and the modes in which it stays on, the core retention voltage in standby and in hibernate, whether the switched core regulators keep running in standby, the charge-pump set, and the active core voltage. All regulator outputs are registered. They reflect the field values and the mode that the clock edge samples.

Top module: `pmreg_ctrl`

## Requirements
- R1: After reset the word reads 0x00000004. Until the first write, with the mode at active (code 0) and the fuse input low, the outputs are uldo_en=0, uldo_lvl=0, sw_core_en=1, core_lvl=0, cp_mux_en=0 and cp_adc_en=0.
- R2: The word sits at byte offset 0x1C. A write with bus_we high at that offset updates the fields. Reads at any other offset return 0, and writes to any other offset change nothing.
- R3: Bit 31 is the backup-valid flag and bit 30 is the SRAM-valid flag. A write stores the written value in each flag. A bkup_lost pulse clears bit 31 and a sram_lost pulse clears bit 30. When a pulse and a write to its flag occur in the same cycle, the flag ends at 0.
- R4: Only bits 31, 30, 15:12, 9:8, 5, 4, 2 and 1:0 can ever read as 1. All other bits read 0 and ignore writes.
- R5: The charge-pump field (bits 11:8) accepts the codes 0x0, 0x1 and 0x3. A write carrying any other code leaves the field unchanged, while the other fields of that write still update. In every mode, cp_mux_en is 1 when the field is nonzero, and cp_adc_en is 1 when the field is 0x3.
- R6: uldo_lvl always equals bits 15:14 (0=1.2 V, 1=1.5 V, 2=1.8 V, 3=2.5 V). uldo_en is bit 12 in active mode, bit 12 AND bit 13 in standby, and 0 in hibernate and in backup.
- R7: Mode codes are 0 active, 1 standby, 2 hibernate and 3 backup. Core level codes are 0=1.2 V, 1=1.0 V and 2=0.8 V. In active mode sw_core_en=1, and core_lvl equals bits 1:0 when fuse_en is high, except that code 3 gives 0. core_lvl is 0 when fuse_en is low.
- R8: In standby, sw_core_en equals bit 2, and core_lvl is 2 if bit 4 is set and 0 otherwise.
- R9: In hibernate, sw_core_en=0, and core_lvl is 2 if bit 5 is set and 0 otherwise. In backup, sw_core_en=0 and core_lvl=0.
- R10: The outputs change at the first clock edge that samples a new mode, a new fuse level or a register write. No further delay is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the addressed word |
| pwr_mode | input | 2 | Current power mode code |
| fuse_en | input | 1 | Allows software choice of the active core voltage |
| bkup_lost | input | 1 | Backup domain power-loss pulse |
| sram_lost | input | 1 | SRAM domain power-loss pulse |
| uldo_en | output | 1 | User LDO enable |
| uldo_lvl | output | 2 | User LDO level code |
| sw_core_en | output | 1 | Switched core regulator enable |
| core_lvl | output | 2 | Core voltage code |
| cp_mux_en | output | 1 | I/O mux and comparator charge pumps enable |
| cp_adc_en | output | 1 | ADC charge pump enable |

## Verification
A wrong stored field appears on bus_rdata in the cycle after the write that set it. It also appears on the regulator outputs at that same edge, as long as the mode in force uses that field. A fault in the mode decode can stay hidden until the bench moves the mode into the one state that uses the faulty term. For that reason the stimulus changes the mode often, sometimes every cycle. Flag-clear faults appear on read data one edge after the loss pulse.

// File: rtl/pmreg_pkg.sv
package pmreg_pkg;

  localparam int DATA_W  = 32;
  localparam int NDOM    = 2;   // index 1 backup domain, index 0 SRAM domain
  localparam int VLD_TOP = 31;

  typedef enum logic [1:0] {
    PM_ACTIVE    = 2'd0,
    PM_STANDBY   = 2'd1,
    PM_HIBERNATE = 2'd2,
    PM_BACKUP    = 2'd3
  } pmode_e;

  localparam logic [1:0] LV_1V2 = 2'd0;
  localparam logic [1:0] LV_0V8 = 2'd2;
  localparam logic [1:0] LV_RSV = 2'd3;

  localparam logic [3:0] CP_NONE = 4'h0;
  localparam logic [3:0] CP_MUX  = 4'h1;
  localparam logic [3:0] CP_ALL  = 4'h3;

  typedef struct packed {
    logic [1:0] uldo_lvl;
    logic       uldo_stby;
    logic       uldo_en;
    logic [1:0] cp;
    logic       lv_hib;
    logic       lv_stby;
    logic       sw_stby;
    logic [1:0] act_lvl;
  } fields_t;

  localparam fields_t FIELDS_RST = '{uldo_lvl: 2'd0, uldo_stby: 1'b0, uldo_en: 1'b0,
                                     cp: 2'd0, lv_hib: 1'b0, lv_stby: 1'b0,
                                     sw_stby: 1'b1, act_lvl: 2'd0};

  typedef struct packed {
    logic       uldo_en;
    logic [1:0] uldo_lvl;
    logic       sw_en;
    logic [1:0] core_lvl;
    logic       cp_mux;
    logic       cp_adc;
  } regout_t;

  localparam regout_t REGOUT_RST = '{uldo_en: 1'b0, uldo_lvl: 2'd0, sw_en: 1'b1,
                                     core_lvl: 2'd0, cp_mux: 1'b0, cp_adc: 1'b0};

  function automatic logic cp_legal(input logic [3:0] code);
    return (code == CP_NONE) || (code == CP_MUX) || (code == CP_ALL);
  endfunction

  function automatic fields_t apply_write(input fields_t old, input logic [DATA_W-1:0] w);
    fields_t n;
    n.uldo_lvl  = w[15:14];
    n.uldo_stby = w[13];
    n.uldo_en   = w[12];
    n.cp        = cp_legal(w[11:8]) ? w[9:8] : old.cp;
    n.lv_hib    = w[5];
    n.lv_stby   = w[4];
    n.sw_stby   = w[2];
    n.act_lvl   = w[1:0];
    return n;
  endfunction

  function automatic logic [DATA_W-1:0] pack_word(input fields_t f, input logic [NDOM-1:0] vld);
    logic [DATA_W-1:0] w;
    w                 = '0;
    w[VLD_TOP -: NDOM] = vld;
    w[15:14]          = f.uldo_lvl;
    w[13]             = f.uldo_stby;
    w[12]             = f.uldo_en;
    w[9:8]            = f.cp;
    w[5]              = f.lv_hib;
    w[4]              = f.lv_stby;
    w[2]              = f.sw_stby;
    w[1:0]            = f.act_lvl;
    return w;
  endfunction

endpackage

// File: rtl/pmreg_fields.sv
module pmreg_fields
  import pmreg_pkg::*;
#(
  parameter int              ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NDOM-1:0]   lost,
  output fields_t           fld_q,
  output fields_t           fld_d,
  output logic [NDOM-1:0]   vld_q
);

  logic wr_hit;

  always_comb begin
    wr_hit = we && (addr == REG_OFS);
    fld_d  = wr_hit ? apply_write(fld_q, wdata) : fld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q <= FIELDS_RST;
    end else if (wr_hit) begin
      fld_q <= fld_d;
    end
  end

  // one software-set, hardware-cleared flag per retained domain
  for (genvar g = 0; g < NDOM; g++) begin : g_vld
    localparam int BITPOS = VLD_TOP - NDOM + 1 + g;
    logic en, d;

    always_comb begin
      en = wr_hit || lost[g];
      d  = lost[g] ? 1'b0 : wdata[BITPOS];   // loss beats a same-cycle write
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
      end else if (en) begin
        vld_q[g] <= d;
      end
    end
  end

endmodule

// File: rtl/pmreg_decode.sv
module pmreg_decode
  import pmreg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  fields_t fld,
  input  pmode_e  mode,
  input  logic    fuse_en,
  output regout_t out_q
);

  regout_t out_d;

  always_comb begin
    out_d          = REGOUT_RST;
    out_d.uldo_lvl = fld.uldo_lvl;
    out_d.cp_mux   = (fld.cp != 2'd0);
    out_d.cp_adc   = (fld.cp == 2'd3);
    unique case (mode)
      PM_ACTIVE: begin
        out_d.uldo_en  = fld.uldo_en;
        out_d.sw_en    = 1'b1;
        out_d.core_lvl = (fuse_en && fld.act_lvl != LV_RSV) ? fld.act_lvl : LV_1V2;
      end
      PM_STANDBY: begin
        out_d.uldo_en  = fld.uldo_en && fld.uldo_stby;
        out_d.sw_en    = fld.sw_stby;
        out_d.core_lvl = fld.lv_stby ? LV_0V8 : LV_1V2;
      end
      PM_HIBERNATE: begin
        out_d.uldo_en  = 1'b0;
        out_d.sw_en    = 1'b0;
        out_d.core_lvl = fld.lv_hib ? LV_0V8 : LV_1V2;
      end
      default: begin
        out_d.uldo_en  = 1'b0;
        out_d.sw_en    = 1'b0;
        out_d.core_lvl = LV_1V2;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= REGOUT_RST;
    end else begin
      out_q <= out_d;
    end
  end

endmodule

// File: rtl/pmreg_ctrl.sv
module pmreg_ctrl
  import pmreg_pkg::*;
#(
  parameter int              ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [1:0]        pwr_mode,
  input  logic              fuse_en,
  input  logic              bkup_lost,
  input  logic              sram_lost,
  output logic              uldo_en,
  output logic [1:0]        uldo_lvl,
  output logic              sw_core_en,
  output logic [1:0]        core_lvl,
  output logic              cp_mux_en,
  output logic              cp_adc_en
);

  logic            rst_meta_n, rst_sync_n;
  fields_t         fld_q, fld_d;
  logic [NDOM-1:0] vld_q;
  logic [31:0]     reg_word;
  regout_t         outs;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  pmreg_fields #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_fields (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .addr  (bus_addr),
    .we    (bus_we),
    .wdata (bus_wdata),
    .lost  ({bkup_lost, sram_lost}),
    .fld_q (fld_q),
    .fld_d (fld_d),
    .vld_q (vld_q)
  );

  pmreg_decode u_decode (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .fld     (fld_d),
    .mode    (pmode_e'(pwr_mode)),
    .fuse_en (fuse_en),
    .out_q   (outs)
  );

  always_comb begin
    reg_word   = pack_word(fld_q, vld_q);
    bus_rdata  = (bus_addr == REG_OFS) ? reg_word : '0;
    uldo_en    = outs.uldo_en;
    uldo_lvl   = outs.uldo_lvl;
    sw_core_en = outs.sw_en;
    core_lvl   = outs.core_lvl;
    cp_mux_en  = outs.cp_mux;
    cp_adc_en  = outs.cp_adc;
  end

endmodule

// File: rtl/pmreg_ctrl_chk.sv
module pmreg_ctrl_chk
  import pmreg_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] reg_word,
  input logic [1:0]  pwr_mode,
  input logic        fuse_en,
  input logic        bkup_lost,
  input logic        sram_lost,
  input logic        uldo_en,
  input logic        sw_core_en,
  input logic [1:0]  core_lvl,
  input logic        cp_mux_en,
  input logic        cp_adc_en
);

  p_bkup_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bkup_lost |=> !reg_word[31]);

  p_sram_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sram_lost |=> !reg_word[30]);

  p_unimpl_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_word & ~32'hC000_F337) == 32'h0);

  p_cp_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cp_adc_en |-> cp_mux_en);

  p_uldo_deep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == PM_HIBERNATE || pwr_mode == PM_BACKUP) |=> !uldo_en);

  p_fuse_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fuse_en && pwr_mode == PM_ACTIVE) |=> (core_lvl == LV_1V2 && sw_core_en));

  p_sw_off_deep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == PM_HIBERNATE || pwr_mode == PM_BACKUP) |=> !sw_core_en);

  p_backup_lvl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == PM_BACKUP) |=> (core_lvl == LV_1V2));

endmodule

bind pmreg_ctrl pmreg_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .reg_word   (reg_word),
  .pwr_mode   (pwr_mode),
  .fuse_en    (fuse_en),
  .bkup_lost  (bkup_lost),
  .sram_lost  (sram_lost),
  .uldo_en    (uldo_en),
  .sw_core_en (sw_core_en),
  .core_lvl   (core_lvl),
  .cp_mux_en  (cp_mux_en),
  .cp_adc_en  (cp_adc_en)
);

// File: tb/pmreg_ctrl_tb.sv
module pmreg_ctrl_tb;

  localparam logic [7:0] OFS = 8'h1C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [1:0]  pwr_mode;
  logic        fuse_en, bkup_lost, sram_lost;
  logic        uldo_en, sw_core_en, cp_mux_en, cp_adc_en;
  logic [1:0]  uldo_lvl, core_lvl;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] model;

  always #4 clk = ~clk;

  pmreg_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_mode(pwr_mode),
    .fuse_en(fuse_en), .bkup_lost(bkup_lost), .sram_lost(sram_lost),
    .uldo_en(uldo_en), .uldo_lvl(uldo_lvl), .sw_core_en(sw_core_en),
    .core_lvl(core_lvl), .cp_mux_en(cp_mux_en), .cp_adc_en(cp_adc_en)
  );

  function automatic logic [31:0] next_word(logic [31:0] old, logic we, logic [7:0] a,
                                            logic [31:0] wd, logic bl, logic sl);
    logic [31:0] n = old;
    if (we && a == OFS) begin
      n = wd & 32'hC000_F037;
      if (wd[11:8] == 4'h0 || wd[11:8] == 4'h1 || wd[11:8] == 4'h3) n[11:8] = wd[11:8];
      else n[11:8] = old[11:8];
    end
    if (bl) n[31] = 1'b0;
    if (sl) n[30] = 1'b0;
    return n;
  endfunction

  function automatic logic [7:0] exp_out(logic [31:0] w, logic [1:0] m, logic f);
    logic ue, sw;
    logic [1:0] cl;
    ue = w[12] && (m == 2'd0 || (m == 2'd1 && w[13]));
    case (m)
      2'd0:    begin sw = 1'b1; cl = (f && w[1:0] != 2'd3) ? w[1:0] : 2'd0; end
      2'd1:    begin sw = w[2]; cl = w[4] ? 2'd2 : 2'd0; end
      2'd2:    begin sw = 1'b0; cl = w[5] ? 2'd2 : 2'd0; end
      default: begin sw = 1'b0; cl = 2'd0; end
    endcase
    return {ue, w[15:14], sw, cl, (w[11:8] != 4'h0), (w[11:8] == 4'h3)};
  endfunction

  function automatic string mode_tag(logic [1:0] m);
    return (m == 2'd0) ? "R7" : (m == 2'd1) ? "R8" : "R9";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge sample, check at the next falling edge (R10)
  task automatic step(logic we, logic [7:0] a, logic [31:0] wd, logic [1:0] m,
                      logic f, logic bl, logic sl, string rtag);
    logic [7:0] e;
    bus_we = we; bus_addr = a; bus_wdata = wd; pwr_mode = m;
    fuse_en = f; bkup_lost = bl; sram_lost = sl;
    model = next_word(model, we, a, wd, bl, sl);
    e = exp_out(model, m, f);
    @(negedge clk);
    chk({rtag, " rdata"}, bus_rdata, (a == OFS) ? model : 32'h0);
    chk("R6 uldo", {29'd0, uldo_en, uldo_lvl}, {29'd0, e[7:5]});
    chk({mode_tag(m), " core"}, {29'd0, sw_core_en, core_lvl}, {29'd0, e[4:2]});
    chk("R5 cp", {30'd0, cp_mux_en, cp_adc_en}, {30'd0, e[1:0]});
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2417));
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = OFS; bus_wdata = '0;
    pwr_mode = 2'd0; fuse_en = 1'b0; bkup_lost = 1'b0; sram_lost = 1'b0;
    model = 32'h0000_0004;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset word and outputs
    chk("R1 word", bus_rdata, 32'h0000_0004);
    chk("R1 outs", {24'd0, uldo_en, uldo_lvl, sw_core_en, core_lvl, cp_mux_en, cp_adc_en},
        {24'd0, 8'b0_00_1_00_0_0});

    // R4 all ones: unimplemented bits dropped, illegal cp code 0xF ignored (R5)
    step(1, OFS, 32'hFFFF_FFFF, 2'd0, 1, 0, 0, "R4");
    // R5 legal 3 then reserved 2 keeps 3
    step(1, OFS, 32'h0000_0300, 2'd0, 1, 0, 0, "R5");
    step(1, OFS, 32'h0000_F235, 2'd1, 1, 0, 0, "R5");
    // R3 write flags then hardware clear racing a write
    step(1, OFS, 32'hC000_1000, 2'd0, 1, 0, 0, "R3");
    step(1, OFS, 32'hC000_1000, 2'd0, 1, 1, 0, "R3");
    step(0, OFS, 32'h0, 2'd0, 1, 0, 1, "R3");
    // R2 write elsewhere ignored, read elsewhere zero
    step(1, 8'h18, 32'hFFFF_FFFF, 2'd0, 1, 0, 0, "R2");
    step(0, OFS, 32'h0, 2'd0, 1, 0, 0, "R2");
    // R7 fuse gating and reserved active code
    step(1, OFS, 32'h0000_0002, 2'd0, 0, 0, 0, "R7");
    step(0, OFS, 32'h0, 2'd0, 1, 0, 0, "R7");
    step(1, OFS, 32'h0000_0003, 2'd0, 1, 0, 0, "R7");
    // R8/R9 retention levels and switched regulators across modes
    step(1, OFS, 32'h0000_3034, 2'd1, 1, 0, 0, "R8");
    step(0, OFS, 32'h0, 2'd2, 1, 0, 0, "R9");
    step(0, OFS, 32'h0, 2'd3, 1, 0, 0, "R9");
    step(1, OFS, 32'h0000_1000, 2'd1, 1, 0, 0, "R6");

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] wd = $urandom;
      logic        we = ($urandom % 3) != 0;
      logic [7:0]  a  = (($urandom % 4) != 0) ? OFS : 8'($urandom);
      step(we, a, wd, 2'($urandom), 1'($urandom), ($urandom % 9) == 0,
           ($urandom % 9) == 0, "R2");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule